// File: doc/BRIEF.md
# Internal I/O Bus Latch Interface

This block sits on the peripheral side of a multiplexed 16-bit address/data bus and a 3-bit microcode field. Both are paced by an active-low sync clock. The block samples the sync clock on its own system clock and works out phases and edges from it. It uses them to capture internal I/O commands, capture write data, drive read data and latch the microcode bits.

The bus master marks each sync cycle as either a command phase or a data phase, and marks a data phase as a read or a write. A command is followed through a transparent latch while the sync clock is low and is held once the sync clock returns high. A low memory/I-O select at the end of a command phase makes the cycle an internal I/O cycle. Only then are command decoding, write capture and read drive enabled. The active-low ready output then requests one wait state for that cycle. Acknowledged DMA or bus hold freezes the microcode latch.

Top module: `ioport_latch`

## Requirements
- R1: While reset is asserted and right after it, the held command and the microcode latch read zero, the output enable is low, the ready output is high and no write strobe is given.
- R2: While the sync clock is low during a command phase, the command output follows the bus in the same cycle.
- R3: Once the sync clock is high, the command output holds the last bus value seen in the low phase, and later bus changes have no effect on it.
- R4: Bus bit 0 is the most significant bit of the 16-bit command and data words, and bus bit 15 is the least significant bit. This holds both on input and on output.
- R5: In the data phase of an internal I/O write, the bus word present at the first system clock after the sync clock falls is stored and a one-cycle write strobe is given. Bus changes later in that low phase leave the stored word unchanged.
- R6: The output enable is high only while the sync clock is low, during the data phase of an internal I/O read. It is never high during a command phase. While it is high, the bus output carries the read word.
- R7: The microcode bits are latched at the first system clock after the sync clock falls. They are not latched when the DMA acknowledge or the hold acknowledge input is low.
- R8: The decode-enable output is set at the end of a command phase only if the memory/I-O select was low (0 = I/O), and it stays at that value until the next command phase ends.
- R9: After an internal I/O command phase ends, the ready output goes low for exactly one system clock cycle, which requests one wait state. It stays high for memory cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sync clock |
| rst_n | input | 1 | Active-low reset |
| sync_n | input | 1 | Active-low bus sync clock |
| cmd_phase | input | 1 | High when the current sync cycle carries a command |
| rd_cycle | input | 1 | High when the data phase is a read |
| mem_io_n | input | 1 | Memory/I-O select, low selects I/O |
| dma_ack_n | input | 1 | Active-low DMA acknowledge |
| hold_ack_n | input | 1 | Active-low bus hold acknowledge |
| mcode | input | 3 | Microcode field bits |
| ad_in | input | 16 | Bus input, index 0 is the MSB |
| ad_out | output | 16 | Bus output, index 0 is the MSB |
| ad_oe | output | 1 | Bus output enable |
| rd_word | input | 16 | Read-response word to place on the bus |
| cmd_word | output | 16 | Command word, transparent or held |
| dec_en | output | 1 | Command decoding enable |
| wr_word | output | 16 | Captured write word |
| wr_stb | output | 1 | One-cycle write capture strobe |
| mc_q | output | 3 | Latched microcode bits |
| ready_n | output | 1 | Active-low wait-state request |

## Verification
The hardest case to reach from the ports is a bus that changes again inside a single low phase. Only that shows the difference between transparent following and edge capture, for both the command and the write word. Each vector therefore drives one word, checks it, swaps it for its complement while the sync clock is still low, and checks again. The same vectors pair the microcode field with DMA and hold acknowledges so that the latch must keep a value written in an earlier vector.

// File: rtl/ioport_latch.sv
module ioport_latch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_n,
  input  logic        cmd_phase,
  input  logic        rd_cycle,
  input  logic        mem_io_n,
  input  logic        dma_ack_n,
  input  logic        hold_ack_n,
  input  logic [2:0]  mcode,
  input  logic [0:15] ad_in,
  output logic [0:15] ad_out,
  output logic        ad_oe,
  input  logic [15:0] rd_word,
  output logic [15:0] cmd_word,
  output logic        dec_en,
  output logic [15:0] wr_word,
  output logic        wr_stb,
  output logic [2:0]  mc_q,
  output logic        ready_n
);

  logic        sync_q;
  logic [15:0] bus_word;
  logic [15:0] cmd_hold;
  logic        io_sel;
  logic        rdy_q;
  logic        fall, rise;

  assign bus_word = ad_in;
  assign fall     = sync_q & ~sync_n;
  assign rise     = ~sync_q & sync_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 1'b1;
    else        sync_q <= sync_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cmd_hold <= '0;
    else if (!sync_n && cmd_phase) cmd_hold <= bus_word;

  assign cmd_word = (!sync_n && cmd_phase) ? bus_word : cmd_hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      io_sel <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= rise && cmd_phase && !mem_io_n;
      if (rise && cmd_phase) io_sel <= ~mem_io_n;
    end

  assign dec_en  = io_sel;
  assign ready_n = ~rdy_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_word <= '0;
      wr_stb  <= 1'b0;
    end else begin
      wr_stb <= fall && !cmd_phase && io_sel && !rd_cycle;
      if (fall && !cmd_phase && io_sel && !rd_cycle) wr_word <= bus_word;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mc_q <= '0;
    else if (fall && dma_ack_n && hold_ack_n) mc_q <= mcode;

  assign ad_oe  = !sync_n && !cmd_phase && rd_cycle && io_sel;
  assign ad_out = rd_word;

  p_oe_low_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!sync_n && !cmd_phase));
  p_ready_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n |=> ready_n);
  p_mc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_ack_n || !hold_ack_n) |=> $stable(mc_q));
  p_cmd_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && $past(sync_n)) |-> $stable(cmd_word));
  p_wr_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (!sync_n && dec_en && !ad_oe));

endmodule

// File: tb/sim_ioport_latch.sv
module sim_ioport_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, cmd_phase = 1'b0, rd_cycle = 1'b0, mem_io_n = 1'b1;
  logic dma_ack_n = 1'b1, hold_ack_n = 1'b1;
  logic [2:0] mcode = '0;
  logic [0:15] ad_in = '0;
  logic [0:15] ad_out;
  logic [15:0] rd_word = '0, cmd_word, wr_word;
  logic ad_oe, dec_en, wr_stb, ready_n;
  logic [2:0] mc_q;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ioport_latch u0 (.clk, .rst_n, .sync_n, .cmd_phase, .rd_cycle, .mem_io_n,
    .dma_ack_n, .hold_ack_n, .mcode, .ad_in, .ad_out, .ad_oe, .rd_word,
    .cmd_word, .dec_en, .wr_word, .wr_stb, .mc_q, .ready_n);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {mem_io_n, rd, dma_n, hold_n, mcode, exp_mc, cmd, data}
  localparam logic [41:0] VEC [4] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 3'd5, 3'd5, 16'hA51C, 16'h3C96},
    {1'b0, 1'b1, 1'b0, 1'b1, 3'd2, 3'd5, 16'h0F0F, 16'hBEEF},
    {1'b1, 1'b0, 1'b1, 1'b0, 3'd6, 3'd5, 16'h7E81, 16'h1357},
    {1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 3'd3, 16'hC003, 16'h8421}
  };

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmd", cmd_word, 16'h0);
    chk("R1 mc", {13'd0, mc_q}, 16'h0);
    chk("R1 oe/rdy/stb", {13'd0, ad_oe, ready_n, wr_stb}, 16'h2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {13'd0, ad_oe, ready_n, wr_stb}, 16'h2);

    for (int i = 0; i < 4; i++) begin
      logic io, rd, wr;
      logic [15:0] c, d;
      io = ~VEC[i][41]; rd = VEC[i][40];
      c = VEC[i][31:16]; d = VEC[i][15:0];
      wr = io & ~rd;
      // command phase
      cmd_phase = 1'b1; mem_io_n = VEC[i][41]; rd_cycle = rd;
      dma_ack_n = VEC[i][39]; hold_ack_n = VEC[i][38]; mcode = VEC[i][37:35];
      ad_in = c; sync_n = 1'b0;
      #1 chk("R2 transparent", cmd_word, c);
      @(negedge clk);
      chk("R7 mcode latch/gate", {13'd0, mc_q}, {13'd0, VEC[i][34:32]});
      ad_in = ~c;
      #1 chk("R2 follows change", cmd_word, ~c);
      ad_in = c;
      @(negedge clk);
      sync_n = 1'b1;
      @(negedge clk);
      chk("R9 ready low", {15'd0, ready_n}, {15'd0, ~io});
      chk("R8 decode enable", {15'd0, dec_en}, {15'd0, io});
      ad_in = 16'h1234;
      @(negedge clk);
      chk("R9 ready one cycle", {15'd0, ready_n}, 16'h1);
      chk("R3 held", cmd_word, c);
      // data phase
      cmd_phase = 1'b0; rd_word = d; ad_in = d; sync_n = 1'b0;
      #1 chk("R6 oe in low", {15'd0, ad_oe}, {15'd0, rd & io});
      if (rd & io) chk("R6 read word", ad_out, d);
      @(negedge clk);
      chk("R5 strobe", {15'd0, wr_stb}, {15'd0, wr});
      if (wr) chk("R5 captured", wr_word, d);
      ad_in = ~d;
      @(negedge clk);
      if (wr) chk("R5 ignores later change", wr_word, d);
      chk("R8 held through data", {15'd0, dec_en}, {15'd0, io});
      sync_n = 1'b1;
      #1 chk("R6 oe off in high", {15'd0, ad_oe}, 16'h0);
      @(negedge clk);
    end

    // bit order: bus bit 0 is MSB
    cmd_phase = 1'b1; ad_in = '0; ad_in[0] = 1'b1; sync_n = 1'b0;
    #1 chk("R4 bus bit0 is MSB", cmd_word, 16'h8000);
    rd_word = 16'h0001;
    #1 chk("R4 out bit15 is LSB", {15'd0, ad_out[15]}, 16'h1);
    chk("R6 no drive in cmd phase", {15'd0, ad_oe}, 16'h0);
    @(negedge clk);
    sync_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1 chk("R1 reset clears cmd", cmd_word, 16'h0);
    chk("R1 reset clears mc", {13'd0, mc_q}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule